// File: doc/BRIEF.md
# Multi-Slot In-Order Retire Controller

This block is the retire side of an out-of-order core. Each dispatched instruction gets a token in a circular buffer of `DEPTH` slots. An instruction may take several slots, one for each of its micro-ops. The token index returned at dispatch is the slot where the instruction's record starts. The execution units later quote that index to mark the instruction as finished.

Every cycle the controller looks at the oldest token. If it has executed, the controller retires it, and the walk continues to younger tokens for as long as each one has executed, up to the per-cycle limit. Retired instructions appear on numbered retire lanes with their tags, lane 0 being the oldest. Their slots return to the free pool. A full/empty pair and a live free-slot count describe the buffer's occupancy.

Top module: `retire_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it rises, the buffer is empty: `avail_o` equals `DEPTH`, `empty_o`=1, `full_o`=0, `disp_token_o`=0 and no retire lane is valid.
- R2: A dispatch is taken on a clock edge where `disp_valid_i` and `disp_ready_o` are both 1. `disp_token_o` shows the current allocation index. After the edge that index has moved forward by the reserved slot count, and `avail_o` has dropped by that count.
- R3: The reserved slot count is the micro-op count clamped to the range 1 to `DEPTH`. A request of 0 takes one slot, and a request above `DEPTH` takes the whole buffer.
- R4: `disp_ready_o` is 1 exactly when `avail_o` is at least the clamped count. A dispatch offered while it is 0 changes neither the allocation index nor the free count.
- R5: A completion on `cmpl_token_i` marks that token executed on the next edge. If it is the oldest token, lane 0 is valid in the following cycle with that instruction's tag.
- R6: An executed token never retires while an older token has not yet executed.
- R7: At most `MAX_RET` tokens retire per cycle (`MAX_RET`=0 means no limit). Lane k carries the k-th oldest retiring token's tag in bits `[k*TAG_W +: TAG_W]`, and the valid lanes are always contiguous from lane 0.
- R8: On the edge that ends a retire cycle, every retiring token's reserved slots return to `avail_o`, and the oldest-token index moves past them.
- R9: `full_o` is 1 exactly when `avail_o` is 0, and `empty_o` is 1 exactly when `avail_o` equals `DEPTH`.
- R10: A dispatch and a retirement in the same cycle are both honoured. The new free count is the old count minus the dispatched slots plus the retired slots. Readiness is judged on the count held before that edge.
- R11: Token indices wrap modulo `DEPTH`, for both the allocation index and the oldest-token index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_tag_i | input | TAG_W | Instruction tag stored with the token |
| disp_uops_i | input | UOP_W | Requested slot count before clamping |
| disp_ready_o | output | 1 | Enough free slots for the current request |
| disp_token_o | output | $clog2(DEPTH) | Token index given to the request |
| cmpl_valid_i | input | 1 | Execution-complete event |
| cmpl_token_i | input | $clog2(DEPTH) | Token index that finished |
| ret_valid_o | output | LANES | Retire lane valids, lane 0 oldest |
| ret_tag_o | output | LANES*TAG_W | Tags of the retiring instructions, one per lane |
| avail_o | output | $clog2(DEPTH+1) | Free slot count |
| full_o | output | 1 | No free slot |
| empty_o | output | 1 | No token in flight |

## Verification
Dispatch and retirement can fall in the same cycle. The bench provokes this by completing two older tokens so that both retire in the cycle where a new dispatch is offered. A request that is only just satisfiable by the count held before the edge must be accepted at the correct index, and the free count after the edge must show the subtraction and the refund together. Completion and retirement also meet. A completion aimed at a younger token must stay invisible on the retire lanes until the head completes, and then both must leave in a single cycle, in order.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  function automatic int unsigned ptr_add(int unsigned p, int unsigned n, int unsigned d);
    int unsigned s;
    s = p + n;
    return (s >= d) ? s - d : s;
  endfunction

  // 0 -> 1, above depth -> depth
  function automatic int unsigned clamp_slots(int unsigned req, int unsigned d);
    if (req == 0) return 1;
    if (req > d) return d;
    return req;
  endfunction

endpackage

// File: rtl/rcu_alloc.sv
module rcu_alloc
  import rcu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int UOP_W = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_valid_i,
  input  logic [UOP_W-1:0] disp_uops_i,
  input  logic [CNT_W-1:0] ret_slots_i,
  input  logic [PTR_W-1:0] ret_head_i,
  output logic             ready_o,
  output logic             fire_o,
  output logic [CNT_W-1:0] nslots_o,
  output logic [PTR_W-1:0] alloc_o,
  output logic [PTR_W-1:0] head_o,
  output logic [CNT_W-1:0] avail_o,
  output logic [CNT_W-1:0] used_o
);

  logic [PTR_W-1:0] alloc_q, head_q;
  logic [CNT_W-1:0] avail_q, avail_d;

  assign nslots_o = CNT_W'(clamp_slots(int'(disp_uops_i), DEPTH));
  assign ready_o  = avail_q >= nslots_o;
  assign fire_o   = disp_valid_i && ready_o;

  always_comb begin
    avail_d = avail_q + ret_slots_i;
    if (fire_o) avail_d = avail_d - nslots_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_q <= '0;
      head_q  <= '0;
      avail_q <= CNT_W'(DEPTH);
    end else begin
      if (fire_o) alloc_q <= PTR_W'(ptr_add(int'(alloc_q), int'(nslots_o), DEPTH));
      head_q  <= ret_head_i;
      avail_q <= avail_d;
    end
  end

  assign alloc_o = alloc_q;
  assign head_o  = head_q;
  assign avail_o = avail_q;
  assign used_o  = CNT_W'(DEPTH) - avail_q;

  p_reject_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && !ready_o && ret_slots_i == '0) |=> ($stable(avail_q) && $stable(alloc_q)));

  p_full_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_q == '0) |-> !ready_o);

  p_retire_grows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_slots_i != '0 && !fire_o) |=> (avail_q > $past(avail_q)));

endmodule

// File: rtl/rcu_token_store.sv
module rcu_token_store #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  parameter int LANES = 2,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [PTR_W-1:0]                wr_ptr_i,
  input  logic [TAG_W-1:0]                wr_tag_i,
  input  logic [CNT_W-1:0]                wr_nsl_i,
  input  logic                            cmpl_i,
  input  logic [PTR_W-1:0]                cmpl_ptr_i,
  input  logic [LANES-1:0]                ret_valid_i,
  input  logic [LANES-1:0][PTR_W-1:0]     ret_pos_i,
  output logic [DEPTH-1:0]                exec_o,
  output logic [DEPTH-1:0][CNT_W-1:0]     nsl_o,
  output logic [DEPTH-1:0][TAG_W-1:0]     tag_o
);

  logic [DEPTH-1:0] exec_q, exec_d;
  logic [DEPTH-1:0][CNT_W-1:0] nsl_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;

  always_comb begin
    exec_d = exec_q;
    for (int k = 0; k < LANES; k++)
      if (ret_valid_i[k]) exec_d[ret_pos_i[k]] = 1'b0;
    if (cmpl_i) exec_d[cmpl_ptr_i] = 1'b1;
    if (wr_i)   exec_d[wr_ptr_i]   = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exec_q <= '0;
    else         exec_q <= exec_d;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      nsl_q[wr_ptr_i] <= wr_nsl_i;
      tag_q[wr_ptr_i] <= wr_tag_i;
    end
  end

  assign exec_o = exec_q;
  assign nsl_o  = nsl_q;
  assign tag_o  = tag_q;

  p_cmpl_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && ret_valid_i == '0 && !(wr_i && wr_ptr_i == cmpl_ptr_i))
      |=> exec_q[$past(cmpl_ptr_i)]);

endmodule

// File: rtl/rcu_retire_sel.sv
module rcu_retire_sel
  import rcu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PTR_W-1:0]            head_i,
  input  logic [CNT_W-1:0]            used_i,
  input  logic [DEPTH-1:0]            exec_i,
  input  logic [DEPTH-1:0][CNT_W-1:0] nsl_i,
  output logic [LANES-1:0]            valid_o,
  output logic [LANES-1:0][PTR_W-1:0] pos_o,
  output logic [CNT_W-1:0]            slots_o,
  output logic [PTR_W-1:0]            head_o
);

  localparam int SUM_W = CNT_W + $clog2(LANES + 1);

  logic [PTR_W-1:0] pos [LANES+1];
  logic [PTR_W-1:0] nh  [LANES+1];
  logic [SUM_W-1:0] cum [LANES+1];
  logic [SUM_W-1:0] rs  [LANES+1];
  logic [LANES:0]   ok;

  assign pos[0] = head_i;
  assign nh[0]  = head_i;
  assign cum[0] = '0;
  assign rs[0]  = '0;
  assign ok[0]  = 1'b1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign valid_o[k]  = ok[k] && (cum[k] < SUM_W'(used_i)) && exec_i[pos[k]];
    assign ok[k+1]     = valid_o[k];
    assign cum[k+1]    = cum[k] + SUM_W'(nsl_i[pos[k]]);
    assign pos[k+1]    = PTR_W'(ptr_add(int'(pos[k]), int'(nsl_i[pos[k]]), DEPTH));
    assign rs[k+1]     = valid_o[k] ? cum[k+1] : rs[k];
    assign nh[k+1]     = valid_o[k] ? pos[k+1] : nh[k];
    assign pos_o[k]    = pos[k];
    if (k > 0) begin : g_chk
      p_lane_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[k] |-> valid_o[k-1]);
    end
  end

  assign slots_o = CNT_W'(rs[LANES]);
  assign head_o  = nh[LANES];

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 8,
  parameter int UOP_W   = 5,
  parameter int MAX_RET = 2,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANES  = (MAX_RET == 0) ? DEPTH : MAX_RET
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   disp_valid_i,
  input  logic [TAG_W-1:0]       disp_tag_i,
  input  logic [UOP_W-1:0]       disp_uops_i,
  output logic                   disp_ready_o,
  output logic [PTR_W-1:0]       disp_token_o,
  input  logic                   cmpl_valid_i,
  input  logic [PTR_W-1:0]       cmpl_token_i,
  output logic [LANES-1:0]       ret_valid_o,
  output logic [LANES*TAG_W-1:0] ret_tag_o,
  output logic [CNT_W-1:0]       avail_o,
  output logic                   full_o,
  output logic                   empty_o
);

  logic                        fire;
  logic [CNT_W-1:0]            nslots, used, ret_slots;
  logic [PTR_W-1:0]            alloc, head, next_head;
  logic [DEPTH-1:0]            exec;
  logic [DEPTH-1:0][CNT_W-1:0] nsl;
  logic [DEPTH-1:0][TAG_W-1:0] tags;
  logic [LANES-1:0][PTR_W-1:0] ret_pos;

  rcu_alloc #(.DEPTH(DEPTH), .UOP_W(UOP_W)) u_alloc (
    .clk_i, .rst_ni,
    .disp_valid_i, .disp_uops_i,
    .ret_slots_i (ret_slots),
    .ret_head_i  (next_head),
    .ready_o     (disp_ready_o),
    .fire_o      (fire),
    .nslots_o    (nslots),
    .alloc_o     (alloc),
    .head_o      (head),
    .avail_o     (avail_o),
    .used_o      (used)
  );

  rcu_token_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
    .clk_i, .rst_ni,
    .wr_i        (fire),
    .wr_ptr_i    (alloc),
    .wr_tag_i    (disp_tag_i),
    .wr_nsl_i    (nslots),
    .cmpl_i      (cmpl_valid_i),
    .cmpl_ptr_i  (cmpl_token_i),
    .ret_valid_i (ret_valid_o),
    .ret_pos_i   (ret_pos),
    .exec_o      (exec),
    .nsl_o       (nsl),
    .tag_o       (tags)
  );

  rcu_retire_sel #(.DEPTH(DEPTH), .LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_sel (
    .clk_i, .rst_ni,
    .head_i  (head),
    .used_i  (used),
    .exec_i  (exec),
    .nsl_i   (nsl),
    .valid_o (ret_valid_o),
    .pos_o   (ret_pos),
    .slots_o (ret_slots),
    .head_o  (next_head)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_tag
    assign ret_tag_o[k*TAG_W +: TAG_W] = tags[ret_pos[k]];
  end

  assign disp_token_o = alloc;
  assign full_o       = (avail_o == '0);
  assign empty_o      = (avail_o == CNT_W'(DEPTH));

  p_ret_not_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o[0] |-> !empty_o);

  p_fire_fills_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !empty_o);

endmodule

// File: tb/tb_retire_ctrl.sv
module tb_retire_ctrl;

  typedef struct packed {
    logic [4:0] uops;
    logic [7:0] tag;
    logic       rdy;
    logic [3:0] tok;
    logic [4:0] avail;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{5'd3, 8'hA0, 1'b1, 4'd0, 5'd13},
    '{5'd0, 8'hA1, 1'b1, 4'd3, 5'd12},
    '{5'd5, 8'hA2, 1'b1, 4'd4, 5'd7},
    '{5'd8, 8'hA3, 1'b0, 4'd9, 5'd7},
    '{5'd7, 8'hA4, 1'b1, 4'd9, 5'd0},
    '{5'd1, 8'hA5, 1'b0, 4'd0, 5'd0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dv = 1'b0, cv = 1'b0;
  logic [7:0] dtag = '0;
  logic [4:0] duops = '0;
  logic [3:0] ctok = '0;

  logic rdy, full, empty, u_rdy, u_full, u_empty;
  logic [3:0] tok, u_tok;
  logic [1:0] rv;
  logic [15:0] rt;
  logic [15:0] u_rv;
  logic [127:0] u_rt;
  logic [4:0] avail, u_avail;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  retire_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(dv), .disp_tag_i(dtag), .disp_uops_i(duops),
    .disp_ready_o(rdy), .disp_token_o(tok),
    .cmpl_valid_i(cv), .cmpl_token_i(ctok),
    .ret_valid_o(rv), .ret_tag_o(rt),
    .avail_o(avail), .full_o(full), .empty_o(empty)
  );

  retire_ctrl #(.MAX_RET(0)) dut_u (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(dv), .disp_tag_i(dtag), .disp_uops_i(duops),
    .disp_ready_o(u_rdy), .disp_token_o(u_tok),
    .cmpl_valid_i(cv), .cmpl_token_i(ctok),
    .ret_valid_o(u_rv), .ret_tag_o(u_rt),
    .avail_o(u_avail), .full_o(u_full), .empty_o(u_empty)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    dv = 1'b0;
    cv = 1'b0;
  endtask

  task automatic disp(input int u, input int t);
    dv = 1'b1; duops = 5'(u); dtag = 8'(t);
  endtask

  task automatic cmpl(input int t);
    cv = 1'b1; ctok = 4'(t);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "avail in reset", avail, 16);
    chk("R1", "empty in reset", empty, 1);
    chk("R1", "full in reset", full, 0);
    chk("R1", "token in reset", tok, 0);
    chk("R1", "lanes in reset", rv, 0);
    rst_ni = 1'b1;
    tick();

    // dispatch table: acceptance, clamping, rejection
    foreach (VEC[i]) begin
      disp(VEC[i].uops, VEC[i].tag);
      #1;
      chk("R4", $sformatf("ready vec %0d", i), rdy, VEC[i].rdy);
      chk("R2", $sformatf("token vec %0d", i), tok, VEC[i].tok);
      tick();
      idle();
      #1;
      chk("R2", $sformatf("avail vec %0d", i), avail, VEC[i].avail);
    end
    chk("R9", "full at zero", full, 1);
    chk("R3", "zero uops took one slot, next token", VEC[2].tok, 4);

    // younger done first: must wait
    cmpl(4); tick(); idle(); #1;
    chk("R6", "younger executed held back", rv, 0);

    cmpl(0); tick(); idle(); #1;
    chk("R5", "head retires lane0", rv, 1);
    chk("R5", "head tag", rt[7:0], 8'hA0);
    tick(); #1;
    chk("R8", "slots returned", avail, 3);

    // two retire while a dispatch lands in the same cycle
    cmpl(3); tick(); idle(); #1;
    chk("R7", "two lanes valid", rv, 3);
    chk("R7", "lane0 tag", rt[7:0], 8'hA1);
    chk("R7", "lane1 tag", rt[15:8], 8'hA2);
    disp(2, 8'hA6); #1;
    chk("R10", "ready on pre-edge count", rdy, 1);
    chk("R10", "token during retire", tok, 0);
    tick(); idle(); #1;
    chk("R10", "avail after dispatch+retire", avail, 7);

    cmpl(0); tick(); idle(); #1;
    chk("R6", "new token waits behind head", rv, 0);
    cmpl(9); tick(); idle(); #1;
    chk("R7", "head and follower retire", rv, 3);
    chk("R7", "lane0 tag wrap", rt[7:0], 8'hA4);
    chk("R11", "lane1 wrapped position tag", rt[15:8], 8'hA6);
    tick(); #1;
    chk("R9", "empty when all free", empty, 1);
    chk("R8", "avail full", avail, 16);

    // oversize request clamps to whole buffer
    disp(20, 8'hB0); #1;
    chk("R3", "oversize ready", rdy, 1);
    chk("R3", "oversize token", tok, 2);
    tick(); idle(); #1;
    chk("R3", "oversize took all", avail, 0);
    cmpl(2); tick(); idle(); #1;
    chk("R5", "oversize retires", rv, 1);
    chk("R5", "oversize tag", rt[7:0], 8'hB0);
    tick(); #1;
    chk("R8", "oversize returned", avail, 16);

    // allocation wrap
    disp(15, 8'hB1); #1;
    chk("R11", "token before wrap", tok, 2);
    tick();
    disp(1, 8'hB2); #1;
    chk("R11", "token after wrap", tok, 1);
    tick(); idle(); #1;
    chk("R11", "avail after wrap", avail, 0);

    // reset from a busy state
    rst_ni = 1'b0; #1;
    chk("R1", "avail on reset", avail, 16);
    chk("R1", "token on reset", tok, 0);
    chk("R1", "lanes on reset", rv, 0);
    tick();
    rst_ni = 1'b1;
    tick();

    // limited vs unlimited retire width
    disp(1, 8'hC0); tick();
    disp(1, 8'hC1); tick();
    disp(1, 8'hC2); tick(); idle();
    cmpl(2); tick();
    cmpl(1); tick();
    cmpl(0); tick(); idle(); #1;
    chk("R7", "limit two lanes", $countones(rv), 2);
    chk("R7", "unlimited three lanes", $countones(u_rv), 3);
    chk("R7", "unlimited lane2 tag", u_rt[23:16], 8'hC2);

    finish_run();
  end

endmodule